// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Slot-Width Detection

This block takes a serial stereo audio stream made of a bit clock, a word-select line and one data line. It turns that stream into parallel 24-bit samples. Each completed channel word leaves the block as a single registered sample. The sample carries a one-cycle valid strobe and a tag that says whether it belongs to the left or the right channel. Words are sent most significant bit first, and the sender may use any precision. The first 24 bits of each word fill the sample from the top down. Bits after the 24th are dropped. Positions that the word never reached read as zero. With 16-bit slots, the lowest eight sample bits are therefore always zero.

The block counts bit clocks between word-select transitions and reports whether the stream uses narrow (16-bit) or wide (32-bit or longer) channel slots. A static configuration input chooses between two framings. In the standard framing the first data bit follows the word-select transition by one bit clock. In the left-justified framing it arrives in the same bit clock as the transition. The block runs directly on the bit clock. After reset it waits for a full word framed by two word-select transitions before it emits anything, so a partial first word is never delivered.

Top module: `i2s_audio_rx`

## Requirements
- R1: While reset is held and in the cycle after it, `smp_valid` is 0, `slot_wide` is 0 and `smp_data` is all zeros.
- R2: `smp_right` is 0 for a word sent while word-select was low (left) and 1 for a word sent while it was high (right). Samples come out in the order their words were sent.
- R3: With `fmt_lj` = 0 (standard framing), a word's first bit is the data bit sampled one rising bit-clock edge after the edge that first sees the new word-select level. Its last bit is sampled on the edge that first sees the next level.
- R4: With `fmt_lj` = 1 (left-justified framing), a word's first bit is sampled on the same rising edge that first sees the new word-select level.
- R5: A word's first bit lands on `smp_data[23]`, and the bit received in position i (counting from 0) lands on `smp_data[23-i]`.
- R6: In a word longer than 24 bits, every bit after the 24th is discarded and has no effect on `smp_data`.
- R7: In a word shorter than 24 bits, the sample bits the word did not reach are zero. For 16-bit words this means `smp_data[7:0]` = 0.
- R8: `slot_wide` changes one cycle after the `smp_valid` pulse of each completed word. It becomes 0 when that word was exactly 16 bits long, becomes 1 when it was 32 or more bits long, and keeps its value for any other length.
- R9: After reset, no sample is produced until a word-select transition has been seen. The word in progress before that transition is discarded, so the first sample is the word that ends at the second transition.
- R10: Every word that is ended by a word-select transition produces exactly one `smp_valid` pulse, and that pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_lj | input | 1 | Framing select: 0 standard (one-bit delay), 1 left-justified |
| ws | input | 1 | Word-select: low = left channel, high = right channel |
| sd | input | 1 | Serial audio data, most significant bit first |
| smp_data | output | 24 | Completed sample, left-aligned |
| smp_valid | output | 1 | One-cycle strobe for each completed sample |
| smp_right | output | 1 | Channel tag of the sample: 1 = right |
| slot_wide | output | 1 | Detected slot width: 1 = 32 or more bits, 0 = 16 bits |

## Verification
The assertions assume that word-select stays at each level for at least two bit clocks and that `fmt_lj` changes only while reset is held. The single-cycle strobe check and the slot-status checks depend on both assumptions. The stimulus builds every word with a length of 16 to 64 bits, alternates channels strictly, and resets the block before it changes the framing. Lengths are drawn from a fixed-seed random choice among 16, 20, 24, 32, 48 and 64 bits. Directed runs add narrow-to-wide slot switches and a right-channel start.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;
  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_CNT_W    = 7;
  localparam int unsigned DEF_NARROW   = 16;
  localparam int unsigned DEF_WIDE     = 32;

  typedef enum logic {
    FRAME_STD  = 1'b0,
    FRAME_LEFT = 1'b1
  } frame_e;
endpackage

// File: rtl/i2srx_align.sv
module i2srx_align
  import i2srx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fmt_lj,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o,
  output logic start_o
);
  localparam logic [1:0] HIST_FULL = 2'd3;

  logic       ws_q, ws_qq, wse_q, sd_q;
  logic [1:0] hist_q;
  logic       ws_eff;
  logic       hist_ok;

  // Standard framing uses word-select one bit later so its MSB lines up with the level change
  assign ws_eff  = (frame_e'(fmt_lj) == FRAME_LEFT) ? ws_q : ws_qq;
  assign hist_ok = (hist_q == HIST_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q   <= 1'b0;
      ws_qq  <= 1'b0;
      wse_q  <= 1'b0;
      sd_q   <= 1'b0;
      hist_q <= '0;
    end else begin
      ws_q  <= ws_i;
      ws_qq <= ws_q;
      sd_q  <= sd_i;
      wse_q <= ws_eff;
      if (!hist_ok) hist_q <= hist_q + 2'd1;
    end
  end

  assign start_o = hist_ok && (ws_eff != wse_q);
  assign ws_o    = ws_eff;
  assign sd_o    = sd_q;
endmodule

// File: rtl/i2srx_deser.sv
module i2srx_deser #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned NARROW   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                valid_o,
  output logic                right_o,
  output logic [CNT_W-1:0]    len_o
);
  localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]    CNT_MAX = '1;
  localparam int unsigned         FILL_W  = SAMPLE_W - NARROW;

  logic [SAMPLE_W-1:0] sh_q, place, next_bits;
  logic [CNT_W-1:0]    cnt_q;
  logic                chan_q, armed_q;

  // The mask walks down one position per bit and becomes zero after the last slot, which drops extra bits
  always_comb begin
    place     = TOP_BIT >> cnt_q;
    next_bits = sh_q | (place & {SAMPLE_W{sd_i}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      chan_q  <= 1'b0;
      armed_q <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      right_o <= 1'b0;
      len_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        if (armed_q) begin
          data_o  <= sh_q;
          right_o <= chan_q;
          len_o   <= cnt_q;
          valid_o <= 1'b1;
        end
        armed_q <= 1'b1;
        sh_q    <= sd_i ? TOP_BIT : '0;
        cnt_q   <= CNT_W'(1);
        chan_q  <= ws_i;
      end else begin
        sh_q <= next_bits;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_no_early_out_r9: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !valid_o);

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && len_o == CNT_W'(NARROW)) |-> (data_o[FILL_W-1:0] == '0));
endmodule

// File: rtl/i2srx_slot_det.sv
module i2srx_slot_det #(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned NARROW = 16,
  parameter int unsigned WIDE   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_vld_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             wide_o
);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_o <= 1'b0;
    end else if (len_vld_i) begin
      if (len_i >= LEN_WIDE)        wide_o <= 1'b1;
      else if (len_i == LEN_NARROW) wide_o <= 1'b0;
    end
  end

  p_narrow_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (len_vld_i && len_i == LEN_NARROW) |=> !wide_o);

  p_wide_slot_r8: assert property (@(posedge clk) disable iff (rst)
    (len_vld_i && len_i >= LEN_WIDE) |=> wide_o);
endmodule

// File: rtl/i2s_audio_rx.sv
module i2s_audio_rx
  import i2srx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned NARROW   = DEF_NARROW,
  parameter int unsigned WIDE     = DEF_WIDE
) (
  input  logic                bclk,
  input  logic                rst,
  input  logic                fmt_lj,
  input  logic                ws,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_valid,
  output logic                smp_right,
  output logic                slot_wide
);
  logic             al_ws, al_sd, al_start;
  logic [CNT_W-1:0] word_len;

  i2srx_align u_align (
    .clk     (bclk),
    .rst     (rst),
    .fmt_lj  (fmt_lj),
    .ws_i    (ws),
    .sd_i    (sd),
    .ws_o    (al_ws),
    .sd_o    (al_sd),
    .start_o (al_start)
  );

  i2srx_deser #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W),
    .NARROW   (NARROW)
  ) u_deser (
    .clk     (bclk),
    .rst     (rst),
    .start_i (al_start),
    .ws_i    (al_ws),
    .sd_i    (al_sd),
    .data_o  (smp_data),
    .valid_o (smp_valid),
    .right_o (smp_right),
    .len_o   (word_len)
  );

  i2srx_slot_det #(
    .CNT_W  (CNT_W),
    .NARROW (NARROW),
    .WIDE   (WIDE)
  ) u_slot (
    .clk       (bclk),
    .rst       (rst),
    .len_vld_i (smp_valid),
    .len_i     (word_len),
    .wide_o    (slot_wide)
  );

  p_single_strobe_r10: assert property (@(posedge bclk) disable iff (rst)
    smp_valid |=> !smp_valid);
endmodule

// File: tb/i2s_audio_rx_tb.sv
module i2s_audio_rx_tb;
  logic        bclk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt_lj = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic [23:0] smp_data;
  logic        smp_valid, smp_right, slot_wide;

  always #2.5 bclk = ~bclk;

  i2s_audio_rx u_dut (
    .bclk(bclk), .rst(rst), .fmt_lj(fmt_lj), .ws(ws), .sd(sd),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_right(smp_right),
    .slot_wide(slot_wide)
  );

  int checks = 0;
  int errors = 0;

  logic [63:0] w_val [0:63];
  int          w_len [0:63];
  logic        w_ch  [0:63];
  int          nw = 0;
  logic        b_sd [0:4095];
  logic        b_ch [0:4095];
  int          nbits = 0;
  logic        cur_ch = 1'b0;
  int          exp_rd = 1;
  logic        exp_wide = 1'b0;
  logic        chk_slot = 1'b0;
  logic        prev_valid = 1'b0;
  int          cyc = 0;

  function automatic logic [23:0] exp_data(input logic [63:0] v, input int len);
    logic [23:0] r = '0;
    for (int i = 0; i < len && i < 24; i++) r[23-i] = v[len-1-i];
    return r;
  endfunction

  task automatic clear_stream(input logic first_ch);
    nw = 0; nbits = 0; cur_ch = first_ch;
  endtask

  task automatic add_word(input int len, input logic [63:0] v);
    w_val[nw] = v; w_len[nw] = len; w_ch[nw] = cur_ch;
    for (int i = 0; i < len; i++) begin
      b_sd[nbits] = v[len-1-i];
      b_ch[nbits] = cur_ch;
      nbits++;
    end
    nw++;
    cur_ch = ~cur_ch;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic int rnd_len();
    int pick = $urandom_range(0, 5);
    case (pick)
      0: return 16; 1: return 20; 2: return 24;
      3: return 32; 4: return 48; default: return 64;
    endcase
  endfunction

  // Monitor: samples outputs at the falling edge
  always @(negedge bclk) begin
    cyc++;
    if (rst) begin
      exp_wide = 1'b0; chk_slot = 1'b0; prev_valid = 1'b0;
    end else begin
      if (chk_slot) begin
        checks++;
        if (slot_wide !== exp_wide) begin
          errors++;
          $display("FAIL R8 slot_wide actual=%0b expected=%0b", slot_wide, exp_wide);
        end
        chk_slot = 1'b0;
      end
      if (smp_valid) begin
        checks++;
        if (prev_valid) begin
          errors++;
          $display("FAIL R10 strobe longer than one cycle actual=1 expected=0");
        end
        if (exp_rd > nw - 2) begin
          errors++;
          $display("FAIL R9 R10 unexpected sample actual=%h expected=none", smp_data);
        end else begin
          checks++;
          if (smp_data !== exp_data(w_val[exp_rd], w_len[exp_rd])) begin
            errors++;
            $display("FAIL %s R5 R6 R7 word %0d len %0d data actual=%h expected=%h",
                     fmt_lj ? "R4" : "R3", exp_rd, w_len[exp_rd], smp_data,
                     exp_data(w_val[exp_rd], w_len[exp_rd]));
          end
          if (smp_right !== w_ch[exp_rd]) begin
            errors++;
            $display("FAIL R2 word %0d tag actual=%0b expected=%0b",
                     exp_rd, smp_right, w_ch[exp_rd]);
          end
          if (w_len[exp_rd] == 16) exp_wide = 1'b0;
          else if (w_len[exp_rd] >= 32) exp_wide = 1'b1;
          chk_slot = 1'b1;
          exp_rd++;
        end
      end
      prev_valid = smp_valid;
    end
  end

  task automatic run(input logic fmt);
    exp_rd = 1;
    @(negedge bclk);
    rst = 1'b1; fmt_lj = fmt; ws = b_ch[0]; sd = 1'b0;
    repeat (3) @(negedge bclk);
    checks++;
    if (smp_valid !== 1'b0 || slot_wide !== 1'b0 || smp_data !== 24'h0) begin
      errors++;
      $display("FAIL R1 reset state actual=%0b/%0b/%h expected=0/0/000000",
               smp_valid, slot_wide, smp_data);
    end
    for (int t = 0; t < nbits; t++) begin
      if (t > 0) @(negedge bclk);
      rst = 1'b0;
      sd  = b_sd[t];
      ws  = fmt ? b_ch[t] : ((t + 1 < nbits) ? b_ch[t+1] : b_ch[t]);
      if (t == 0) begin
        @(negedge bclk);
        checks++;
        if (smp_valid !== 1'b0 || slot_wide !== 1'b0) begin
          errors++;
          $display("FAIL R1 after reset actual=%0b/%0b expected=0/0", smp_valid, slot_wide);
        end
        sd = b_sd[0];
      end
    end
    repeat (8) @(negedge bclk);
    checks++;
    if (exp_rd != nw - 1) begin
      errors++;
      $display("FAIL R10 R9 sample count actual=%0d expected=%0d", exp_rd - 1, nw - 2);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    // Standard framing: wide slots with extra low bits, then narrow, then wide again
    clear_stream(1'b0);
    for (int i = 0; i < 6; i++) add_word(32, rnd64());
    for (int i = 0; i < 6; i++) add_word(16, rnd64());
    for (int i = 0; i < 4; i++) add_word(32, rnd64());
    run(1'b0);

    // Left-justified, right channel first, all-ones words stress truncation and zero fill
    clear_stream(1'b1);
    add_word(16, '1); add_word(16, '1); add_word(16, '1);
    add_word(64, '1); add_word(64, '1); add_word(20, '1);
    add_word(24, '1); add_word(16, '1); add_word(32, 64'h0);
    run(1'b1);

    // Random lengths in both framings
    clear_stream(1'b0);
    for (int i = 0; i < 20; i++) add_word(rnd_len(), rnd64());
    run(1'b0);
    clear_stream(1'b0);
    for (int i = 0; i < 20; i++) add_word(rnd_len(), rnd64());
    run(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d cycles expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule